// File: doc/BRIEF.md
# Serial audio link tag and command slot field checker

This block sits behind a slot deserializer on a frame-based serial audio link. For every completed slot the deserializer raises a one-cycle strobe with the slot number (0, 1 or 2) and the slot value, plus a flag saying whether the slot was travelling from controller to codec (outgoing) or from codec to controller (incoming). The checker takes the tag slot apart into its ready flag, per-slot valid mask and codec identifier. It then decodes the command/status address slot and the command/status data slot, but only when the tag last seen in that direction marks them valid.

The decoded fields are held per direction until the next valid slot of the same kind arrives. Three error flags pulse in the strobe cycle itself: a set reserved bit in the tag, set reserved bits in slot 1 or slot 2 (the reserved set depends on the direction), and an odd register address. Audio slots and the codec register file are left to other blocks.

Top module: `acl_slot_checker`

## Requirements
- R1: After reset every held output (tag_ready, tag_valid, tag_codec, acc_rd, reg_addr, reg_data, req_bits) is zero, and no tag has been seen, so no slot 1 or slot 2 is decoded until a tag arrives.
- R2: A strobe with slot_idx 0 in direction d (index 1 = outgoing, dir_out=1; index 0 = incoming) loads, at the next clock edge, tag_ready[d] from slot_val bit 15, tag_valid[d] from bits 14..3 and tag_codec[d] from bits 1..0; bits 19..16 are ignored.
- R3: err_tag_rsv is high in the cycle of a slot 0 strobe exactly when slot_val bit 2 is set.
- R4: A slot 1 strobe is decoded only when tag_valid[d] bit 11 is set, and a slot 2 strobe only when tag_valid[d] bit 10 is set; otherwise the held outputs do not change and no error flag rises.
- R5: A decoded outgoing slot 1 loads acc_rd[1] from bit 19 (1 = read, 0 = write) and reg_addr[1] from bits 18..12; req_bits[1] stays zero.
- R6: A decoded incoming slot 1 loads reg_addr[0] from bits 18..12 and req_bits[0] from bits 11..2; acc_rd[0] stays zero.
- R7: err_odd_addr is high in the strobe cycle of a decoded slot 1 exactly when bit 12 (the address LSB) is set.
- R8: err_rsv is high in the strobe cycle of a decoded slot 1 when bits 1..0 are non-zero in either direction, when bits 11..2 are non-zero in the outgoing direction, or when bit 19 is set in the incoming direction.
- R9: A decoded slot 2 loads reg_data[d] from bits 19..4, and err_rsv is high in its strobe cycle exactly when bits 3..0 are non-zero.
- R10: The error flags are low in every cycle without a strobe, and a strobe with slot_idx 3 changes nothing and raises no flag.
- R11: A strobe in one direction leaves every held output of the other direction unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_stb | input | 1 | One-cycle strobe: a slot value is present |
| slot_idx | input | 2 | Slot number of the strobed value (0, 1, 2; 3 ignored) |
| dir_out | input | 1 | 1 = outgoing slot, 0 = incoming slot |
| slot_val | input | 20 | Slot value, MSB-first bit order, tag in bits 15..0 |
| tag_ready | output | 2 | Held ready flag per direction |
| tag_valid | output | 2x12 | Held valid mask per direction, bit 11 = slot 1 |
| tag_codec | output | 2x2 | Held codec identifier per direction |
| acc_rd | output | 2 | Held access type per direction (1 = read) |
| reg_addr | output | 2x7 | Held register address per direction |
| reg_data | output | 2x16 | Held data word per direction |
| req_bits | output | 2x10 | Held data-request bits per direction |
| err_tag_rsv | output | 1 | Pulse: tag reserved bit set |
| err_rsv | output | 1 | Pulse: slot 1 or slot 2 reserved bits set |
| err_odd_addr | output | 1 | Pulse: odd register address |

## Verification
The hardest state to reach is a slot arriving whose gating bit is clear in its own direction while the same bit is set in the other direction, since only that separates per-direction gating from a shared mask. The stimulus sweeps all four combinations of the two gating bits in each direction, with tag values whose other bits are pseudo-random, and follows each tag with a run of slot 1 and slot 2 values that alternate between clean reserved fields, even addresses and random contents. A slot 1 sent before any tag and a slot numbered 3 after each run check that undecoded strobes leave every output untouched.

// File: rtl/acl_chk_pkg.sv
package acl_chk_pkg;
  localparam int SLOT_W  = 20;
  localparam int TAG_W   = 16;
  localparam int VALID_W = 12;
  localparam int CODEC_W = 2;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int REQ_W   = 10;
  localparam int NDIR    = 2;
  localparam int IDX_W   = 2;

  localparam int ADDR_LSB  = SLOT_W - 1 - ADDR_W;
  localparam int REQ_LSB   = ADDR_LSB - REQ_W;
  localparam int DATA_LSB  = SLOT_W - DATA_W;
  localparam int TAG_RSV   = CODEC_W;
  localparam int VALID_LSB = TAG_RSV + 1;

  typedef struct packed {
    logic                 ready;
    logic [VALID_W-1:0]   valid;
    logic [CODEC_W-1:0]   codec;
  } tag_t;

  function automatic tag_t f_tag_split(input logic [TAG_W-1:0] v);
    tag_t t;
    t.ready = v[TAG_W-1];
    t.valid = v[VALID_LSB +: VALID_W];
    t.codec = v[CODEC_W-1:0];
    return t;
  endfunction

  function automatic logic f_tag_rsv(input logic [TAG_W-1:0] v);
    return v[TAG_RSV];
  endfunction

  function automatic logic f_s1_rsv(input logic [SLOT_W-1:0] v, input logic is_out);
    logic tail;
    tail = |v[REQ_LSB-1:0];
    if (is_out) return tail | (|v[REQ_LSB +: REQ_W]);
    else        return tail | v[SLOT_W-1];
  endfunction

  function automatic logic f_s2_rsv(input logic [SLOT_W-1:0] v);
    return |v[DATA_LSB-1:0];
  endfunction
endpackage

// File: rtl/acl_tag_split.sv
module acl_tag_split
  import acl_chk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tag_stb,
  input  logic               dir_sel,
  input  logic [TAG_W-1:0]   tag_val,
  output tag_t [NDIR-1:0]    tag_q,
  output logic               err_rsv
);
  assign err_rsv = tag_stb & f_tag_rsv(tag_val);

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic hit;
    assign hit = tag_stb && (dir_sel == 1'(d));
    always_ff @(posedge clk) begin
      if (!rst_n)   tag_q[d] <= '0;
      else if (hit) tag_q[d] <= f_tag_split(tag_val);
    end

    AST_TAG_OTHER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_stb && (dir_sel != 1'(d))) |=> $stable(tag_q[d])); // R11
  end
endmodule

// File: rtl/acl_cmd_field.sv
module acl_cmd_field
  import acl_chk_pkg::*;
#(
  parameter bit IS_OUT = 1'b1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_stb,
  input  logic               data_stb,
  input  logic               addr_en,
  input  logic               data_en,
  input  logic [SLOT_W-1:0]  slot_val,
  output logic               acc_q,
  output logic [ADDR_W-1:0]  addr_q,
  output logic [DATA_W-1:0]  data_q,
  output logic [REQ_W-1:0]   req_q,
  output logic               err_rsv,
  output logic               err_odd
);
  logic take_addr, take_data;
  assign take_addr = addr_stb & addr_en;
  assign take_data = data_stb & data_en;

  assign err_odd = take_addr & slot_val[ADDR_LSB];
  assign err_rsv = (take_addr & f_s1_rsv(slot_val, IS_OUT))
                 | (take_data & f_s2_rsv(slot_val));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (take_addr) addr_q <= slot_val[ADDR_LSB +: ADDR_W];
      if (take_data) data_q <= slot_val[DATA_LSB +: DATA_W];
    end
  end

  if (IS_OUT) begin : g_out
    assign req_q = '0;
    always_ff @(posedge clk) begin
      if (!rst_n)         acc_q <= 1'b0;
      else if (take_addr) acc_q <= slot_val[SLOT_W-1];
    end
  end else begin : g_in
    assign acc_q = 1'b0;
    always_ff @(posedge clk) begin
      if (!rst_n)         req_q <= '0;
      else if (take_addr) req_q <= slot_val[REQ_LSB +: REQ_W];
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_addr |=> $stable(addr_q)); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_data |=> $stable(data_q)); // R4
endmodule

// File: rtl/acl_slot_checker.sv
module acl_slot_checker
  import acl_chk_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           slot_stb,
  input  logic [IDX_W-1:0]               slot_idx,
  input  logic                           dir_out,
  input  logic [SLOT_W-1:0]              slot_val,
  output logic [NDIR-1:0]                tag_ready,
  output logic [NDIR-1:0][VALID_W-1:0]   tag_valid,
  output logic [NDIR-1:0][CODEC_W-1:0]   tag_codec,
  output logic [NDIR-1:0]                acc_rd,
  output logic [NDIR-1:0][ADDR_W-1:0]    reg_addr,
  output logic [NDIR-1:0][DATA_W-1:0]    reg_data,
  output logic [NDIR-1:0][REQ_W-1:0]     req_bits,
  output logic                           err_tag_rsv,
  output logic                           err_rsv,
  output logic                           err_odd_addr
);
  logic tag_stb, s1_stb, s2_stb;
  assign tag_stb = slot_stb && (slot_idx == IDX_W'(0));
  assign s1_stb  = slot_stb && (slot_idx == IDX_W'(1));
  assign s2_stb  = slot_stb && (slot_idx == IDX_W'(2));

  tag_t [NDIR-1:0] tag_q;
  logic [NDIR-1:0] rsv_w, odd_w;

  acl_tag_split i_tag (
    .clk     (clk),
    .rst_n   (rst_n),
    .tag_stb (tag_stb),
    .dir_sel (dir_out),
    .tag_val (slot_val[TAG_W-1:0]),
    .tag_q   (tag_q),
    .err_rsv (err_tag_rsv)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_cmd
    logic mine;
    assign mine         = (dir_out == 1'(d));
    assign tag_ready[d] = tag_q[d].ready;
    assign tag_valid[d] = tag_q[d].valid;
    assign tag_codec[d] = tag_q[d].codec;

    acl_cmd_field #(.IS_OUT(d == 1)) i_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_stb (s1_stb & mine),
      .data_stb (s2_stb & mine),
      .addr_en  (tag_q[d].valid[VALID_W-1]),
      .data_en  (tag_q[d].valid[VALID_W-2]),
      .slot_val (slot_val),
      .acc_q    (acc_rd[d]),
      .addr_q   (reg_addr[d]),
      .data_q   (reg_data[d]),
      .req_q    (req_bits[d]),
      .err_rsv  (rsv_w[d]),
      .err_odd  (odd_w[d])
    );
  end

  assign err_rsv      = |rsv_w;
  assign err_odd_addr = |odd_w;

  AST_ERR_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (err_tag_rsv || err_rsv || err_odd_addr) |-> (slot_stb && (slot_idx != IDX_W'(3)))); // R10
  AST_ODD_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    err_odd_addr |=> reg_addr[$past(dir_out)][0]); // R7
  AST_ERR_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_tag_rsv, err_rsv | err_odd_addr})); // R3
endmodule

// File: tb/test_acl_slot_checker.sv
module test_acl_slot_checker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_stb = 1'b0;
  logic [1:0] slot_idx = '0;
  logic dir_out = 1'b0;
  logic [19:0] slot_val = '0;
  logic [1:0] tag_ready, acc_rd;
  logic [1:0][11:0] tag_valid;
  logic [1:0][1:0] tag_codec;
  logic [1:0][6:0] reg_addr;
  logic [1:0][15:0] reg_data;
  logic [1:0][9:0] req_bits;
  logic err_tag_rsv, err_rsv, err_odd_addr;

  logic [1:0] m_ready, m_rd;
  logic [1:0][11:0] m_valid;
  logic [1:0][1:0] m_codec;
  logic [1:0][6:0] m_addr;
  logic [1:0][15:0] m_data;
  logic [1:0][9:0] m_req;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acl_slot_checker i_acl_slot_checker (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .slot_idx(slot_idx),
    .dir_out(dir_out), .slot_val(slot_val), .tag_ready(tag_ready),
    .tag_valid(tag_valid), .tag_codec(tag_codec), .acc_rd(acc_rd),
    .reg_addr(reg_addr), .reg_data(reg_data), .req_bits(req_bits),
    .err_tag_rsv(err_tag_rsv), .err_rsv(err_rsv), .err_odd_addr(err_odd_addr)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic chk_held(input string ctx);
    for (int d = 0; d < 2; d++) begin
      chk({ctx, " R2 ready"}, 32'(tag_ready[d]), 32'(m_ready[d]));
      chk({ctx, " R2 valid"}, 32'(tag_valid[d]), 32'(m_valid[d]));
      chk({ctx, " R2 codec"}, 32'(tag_codec[d]), 32'(m_codec[d]));
      chk({ctx, " R5 R11 acc_rd"}, 32'(acc_rd[d]), 32'(m_rd[d]));
      chk({ctx, " R5 R6 reg_addr"}, 32'(reg_addr[d]), 32'(m_addr[d]));
      chk({ctx, " R9 reg_data"}, 32'(reg_data[d]), 32'(m_data[d]));
      chk({ctx, " R6 req_bits"}, 32'(req_bits[d]), 32'(m_req[d]));
    end
  endtask

  function automatic logic [19:0] mix(input int a);
    logic [31:0] x;
    x = 32'(a) * 32'h9E3779B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    return x[19:0];
  endfunction

  task automatic send(input logic [1:0] idx, input logic d, input logic [19:0] v, input string ctx);
    logic e_tag, e_rsv, e_odd;
    e_tag = 1'b0; e_rsv = 1'b0; e_odd = 1'b0;
    if (idx == 2'd0) e_tag = v[2];
    if (idx == 2'd1 && m_valid[d][11]) begin
      e_odd = v[12];
      e_rsv = (v[1:0] != 0) || (d ? (v[11:2] != 0) : v[19]);
    end
    if (idx == 2'd2 && m_valid[d][10]) e_rsv = (v[3:0] != 0);
    @(negedge clk);
    slot_stb = 1'b1; slot_idx = idx; dir_out = d; slot_val = v;
    #1;
    chk({ctx, " R3 err_tag_rsv"}, 32'(err_tag_rsv), 32'(e_tag));
    chk({ctx, " R8 R9 err_rsv"}, 32'(err_rsv), 32'(e_rsv));
    chk({ctx, " R7 err_odd_addr"}, 32'(err_odd_addr), 32'(e_odd));
    if (idx == 2'd0) begin
      m_ready[d] = v[15]; m_valid[d] = v[14:3]; m_codec[d] = v[1:0];
    end else if (idx == 2'd1 && m_valid[d][11]) begin
      m_addr[d] = v[18:12];
      if (d) m_rd[1] = v[19];
      else   m_req[0] = v[11:2];
    end else if (idx == 2'd2 && m_valid[d][10]) begin
      m_data[d] = v[19:4];
    end
    @(negedge clk);
    slot_stb = 1'b0;
    #1;
    chk({ctx, " R10 idle err"}, 32'({err_tag_rsv, err_rsv, err_odd_addr}), 32'(0));
    chk_held(ctx);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [19:0] v;
    m_ready = '0; m_rd = '0; m_valid = '0; m_codec = '0;
    m_addr = '0; m_data = '0; m_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_held("R1 reset");
    chk("R1 reset err", 32'({err_tag_rsv, err_rsv, err_odd_addr}), 32'(0));

    // R4: before any tag nothing is decoded
    send(2'd1, 1'b1, 20'hFFFFF, "R4 R1 pre-tag slot1 out");
    send(2'd2, 1'b0, 20'hABCDF, "R4 R1 pre-tag slot2 in");

    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 4; m++) begin
        v = mix(d * 100 + m);
        v[14] = m[0];
        v[13] = m[1];
        send(2'd0, d[0], v, "R2 R3 tag");
        for (int j = 0; j < 16; j++) begin
          v = mix(1000 + d * 4000 + m * 200 + j);
          if (j % 4 == 0) begin
            v[1:0] = 2'b00;
            if (d == 1) v[11:2] = '0;
            else        v[19] = 1'b0;
          end
          if (j % 4 == 1) v[12] = 1'b0;
          send(2'd1, d[0], v, "R4 R5 R6 R7 R8 R11 slot1");
          v = mix(9000 + d * 4000 + m * 200 + j);
          if (j % 2 == 0) v[3:0] = 4'h0;
          send(2'd2, d[0], v, "R4 R9 R11 slot2");
          send(2'd1, ~d[0], mix(50000 + j), "R4 R11 other dir slot1");
        end
        send(2'd3, d[0], 20'hFFFFF, "R10 slot3 ignored");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule